// File: doc/BRIEF.md
# Interrupt Source State Controller

This block holds the per-source state of a small bank of interrupt sources. Each source is set at build time to be either level-sensitive or message-style (edge). Each source keeps a target server, a live priority, a saved priority and four status flags. The flags are asserted, sent, rejected and pending-while-masked. A priority of 0xFF masks a source.

The block watches the source input lines. It takes one command at a time on a small command port. The commands cover configuration writes, switching a source off or on, and the reject, end-of-interrupt and resend notifications that come back from the presentation layer. When a source must be presented, the block raises a request on a valid/ready output. The request carries the target server, the global interrupt number (base offset plus local index) and the priority. Requests leave one at a time, lowest index first.

A command that names a global number outside the bank, or that uses an unknown opcode, is refused with an error response.

Top module: `irq_src_ctrl`

## Requirements
- R1: After reset no present request is raised, the command port is ready, no response is pending, every status flag is clear, and both the live and saved priority of every source are 0xFF.
- R2: A source whose live priority is 0xFF never raises a present request.
- R3: A message source that sees a rising input while masked records it as pending and presents nothing. The first configuration write or enable that unmasks it clears the pending mark and presents it once, at the new priority. A rising input on an unmasked message source presents it at once.
- R4: A level source follows its input in the asserted flag. On an input change, configuration write, enable or resend, it presents only if it is unmasked, asserted and not already sent. Presenting sets the sent flag.
- R5: A reject command (opcode 3) sets the source's rejected flag and clears its sent flag. It presents nothing by itself.
- R6: A resend command (opcode 5, number ignored) evaluates every source. A level source re-presents under R4. A message source with its rejected flag set clears that flag, and re-presents if it is unmasked.
- R7: An end-of-interrupt command (opcode 4) clears the sent flag of a level source. It has no effect on a message source.
- R8: A configuration write (opcode 0) loads the server, the live priority and the saved priority from the command. It then re-evaluates the source under R3 or R4.
- R9: Disable (opcode 1) copies the live priority into the saved priority and sets the live priority to 0xFF. Enable (opcode 2) copies the saved priority back into the live priority and re-evaluates the source.
- R10: A command's global number is valid only when it is at least BASE and below BASE plus NUM_SRC. The response comes one cycle after a command is accepted. It flags an error, and changes no state, when the number is out of range or the opcode is above 5.
- R11: Present requests carry pres_num = BASE + index. While pres_valid is high and pres_ready is low, the number, server and priority on the output stay stable. Pending requests leave in ascending index order.
- R12: cmd_ready is low while any present request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | NUM_SRC | Source input lines, one per local index |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 3 | Opcode: 0 config, 1 disable, 2 enable, 3 reject, 4 EOI, 5 resend |
| cmd_num | input | NUM_W | Global interrupt number the command addresses |
| cmd_srv | input | SRV_W | Server for a configuration write |
| cmd_prio | input | 8 | Priority for a configuration write |
| rsp_valid | output | 1 | Response for the command taken one cycle earlier |
| rsp_err | output | 1 | The command was refused |
| pres_valid | output | 1 | A present request is offered |
| pres_ready | input | 1 | The presentation layer takes the request |
| pres_srv | output | SRV_W | Target server of the request |
| pres_num | output | NUM_W | Global interrupt number of the request |
| pres_prio | output | 8 | Priority of the request |

## Verification
Some properties are checked on every cycle by the assertions:
- a source with a pending-while-masked mark is always masked;
- no request is raised by a masked source;
- a level source raises a request whenever its sent flag rises;
- a message source's sent flag survives an end-of-interrupt;
- a stalled request holds steady;
- each accepted command gets a response, and an underflowing number is flagged.

Other behaviour is shown only by the bench's scenarios, because it depends on a chain of commands. This covers whether a reject followed by a resend brings back the right sources in index order. It also covers whether an enable restores the priority saved by a disable, and whether an out-of-range number leaves the aliased slot untouched.

// File: rtl/isc_pkg.sv
`timescale 1ns/1ps
package isc_pkg;
    localparam int PRIO_W = 8;
    typedef logic [PRIO_W-1:0] prio_t;
    localparam prio_t PRIO_OFF = '1;

    typedef enum logic [2:0] {
        OP_CFG    = 3'd0,
        OP_OFF    = 3'd1,
        OP_ON     = 3'd2,
        OP_REJECT = 3'd3,
        OP_EOI    = 3'd4,
        OP_RESEND = 3'd5
    } op_e;

    localparam logic [2:0] OP_LAST = 3'd5;

    typedef struct packed {
        logic asserted;
        logic sent;
        logic rejected;
        logic mpend;
    } flags_t;

    function automatic logic is_open(prio_t p);
        return p != PRIO_OFF;
    endfunction
endpackage

// File: rtl/isc_slot.sv
`timescale 1ns/1ps
module isc_slot import isc_pkg::*; #(
    parameter bit LEVEL = 1'b0,
    parameter int SRV_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_i,
    input  logic             hit_i,
    input  op_e              op_i,
    input  logic [SRV_W-1:0] srv_i,
    input  prio_t            prio_i,
    input  logic             resend_i,
    input  logic             grant_i,
    output logic             req_o,
    output logic [SRV_W-1:0] srv_o,
    output prio_t            prio_o
);
    flags_t fl_q, fl_d;
    prio_t prio_q, prio_d, save_q, save_d;
    logic [SRV_W-1:0] srv_q, srv_d;
    logic req_q, req_d, reval;

    always_comb begin
        fl_d   = fl_q;
        prio_d = prio_q;
        save_d = save_q;
        srv_d  = srv_q;
        req_d  = req_q & ~grant_i;
        reval  = 1'b0;
        if (hit_i) begin
            case (op_i)
                OP_CFG:    begin srv_d = srv_i; prio_d = prio_i; save_d = prio_i; reval = 1'b1; end
                OP_OFF:    begin prio_d = PRIO_OFF; save_d = prio_q; reval = 1'b1; end
                OP_ON:     begin prio_d = save_q; reval = 1'b1; end
                OP_REJECT: begin fl_d.rejected = 1'b1; fl_d.sent = 1'b0; end
                OP_EOI:    if (LEVEL) fl_d.sent = 1'b0;
                default:   ;
            endcase
        end
        // asserted doubles as the previous line value for edge sources
        fl_d.asserted = line_i;
        if (LEVEL) begin
            if (line_i != fl_q.asserted) reval = 1'b1;
            if ((reval || resend_i) && is_open(prio_d) && fl_d.asserted && !fl_d.sent) begin
                fl_d.sent = 1'b1;
                req_d     = 1'b1;
            end
        end else begin
            if (line_i && !fl_q.asserted) begin
                if (is_open(prio_d)) req_d = 1'b1;
                else                 fl_d.mpend = 1'b1;
            end
            if (reval && fl_d.mpend && is_open(prio_d)) begin
                fl_d.mpend = 1'b0;
                req_d      = 1'b1;
            end
            if (resend_i && fl_d.rejected) begin
                fl_d.rejected = 1'b0;
                if (is_open(prio_d)) req_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fl_q   <= '0;
            prio_q <= PRIO_OFF;
            save_q <= PRIO_OFF;
            srv_q  <= '0;
            req_q  <= 1'b0;
        end else begin
            fl_q   <= fl_d;
            prio_q <= prio_d;
            save_q <= save_d;
            srv_q  <= srv_d;
            req_q  <= req_d;
        end
    end

    assign req_o  = req_q;
    assign srv_o  = srv_q;
    assign prio_o = prio_q;

    a_r2_masked_no_present: assert property (@(posedge clk) disable iff (rst)
        $rose(req_q) |-> prio_q != PRIO_OFF);

    a_r3_pend_only_masked: assert property (@(posedge clk) disable iff (rst)
        fl_q.mpend |-> prio_q == PRIO_OFF);

    if (LEVEL) begin : g_lvl_chk
        a_r4_sent_with_req: assert property (@(posedge clk) disable iff (rst)
            $rose(fl_q.sent) |-> req_q);
    end else begin : g_msg_chk
        a_r7_msg_eoi_inert: assert property (@(posedge clk) disable iff (rst)
            hit_i && op_i == OP_EOI |=> fl_q.sent == $past(fl_q.sent));
    end
endmodule

// File: rtl/isc_pick.sv
`timescale 1ns/1ps
module isc_pick #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req_i,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/irq_src_ctrl.sv
`timescale 1ns/1ps
module irq_src_ctrl import isc_pkg::*; #(
    parameter int                 NUM_SRC   = 16,
    parameter int                 SRV_W     = 4,
    parameter int                 NUM_W     = 16,
    parameter logic [NUM_W-1:0]   BASE      = 16'h1000,
    parameter logic [NUM_SRC-1:0] LEVEL_MAP = 16'h00FF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] line_in,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [2:0]         cmd_op,
    input  logic [NUM_W-1:0]   cmd_num,
    input  logic [SRV_W-1:0]   cmd_srv,
    input  logic [7:0]         cmd_prio,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic               pres_valid,
    input  logic               pres_ready,
    output logic [SRV_W-1:0]   pres_srv,
    output logic [NUM_W-1:0]   pres_num,
    output logic [7:0]         pres_prio
);
    localparam int IDX_W = $clog2(NUM_SRC);
    localparam logic [NUM_W-1:0] CNT = NUM_W'(NUM_SRC);

    op_e              op;
    logic [NUM_W-1:0] off;
    logic             accept, in_range, is_resend, bad, resend_go;
    logic [NUM_SRC-1:0] req, hit, grant;
    logic [SRV_W-1:0] srv_a [NUM_SRC];
    prio_t            prio_a [NUM_SRC];
    logic [IDX_W-1:0] pick_idx, sel, lock_idx_q;
    logic             lock_q, rsp_valid_q, rsp_err_q;

    assign op        = op_e'(cmd_op);
    assign off       = cmd_num - BASE;
    assign in_range  = (cmd_num >= BASE) && (off < CNT);
    assign is_resend = (op == OP_RESEND);
    assign bad       = (cmd_op > OP_LAST) || (!is_resend && !in_range);
    assign cmd_ready = ~|req;
    assign accept    = cmd_valid && cmd_ready;
    assign resend_go = accept && !bad && is_resend;

    isc_pick #(.N(NUM_SRC), .IW(IDX_W)) u_pick (
        .req_i (req),
        .idx_o (pick_idx)
    );

    assign sel        = lock_q ? lock_idx_q : pick_idx;
    assign pres_valid = |req;
    assign pres_num   = BASE + NUM_W'(sel);
    assign pres_srv   = srv_a[sel];
    assign pres_prio  = prio_a[sel];

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign hit[i]   = accept && !bad && !is_resend && (off[IDX_W-1:0] == IDX_W'(i));
        assign grant[i] = pres_valid && pres_ready && (sel == IDX_W'(i));
        isc_slot #(.LEVEL(LEVEL_MAP[i]), .SRV_W(SRV_W)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .line_i   (line_in[i]),
            .hit_i    (hit[i]),
            .op_i     (op),
            .srv_i    (cmd_srv),
            .prio_i   (cmd_prio),
            .resend_i (resend_go),
            .grant_i  (grant[i]),
            .req_o    (req[i]),
            .srv_o    (srv_a[i]),
            .prio_o   (prio_a[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q      <= 1'b0;
            lock_idx_q  <= '0;
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
        end else begin
            lock_q      <= pres_valid && !pres_ready;
            lock_idx_q  <= sel;
            rsp_valid_q <= accept;
            rsp_err_q   <= accept && bad;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_err   = rsp_err_q;

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        pres_valid && !pres_ready |=> pres_valid && $stable(pres_num)
            && $stable(pres_srv) && $stable(pres_prio));

    a_r10_rsp_follows: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready |=> rsp_valid);

    a_r10_low_num_err: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready && cmd_num < BASE && cmd_op != OP_RESEND |=> rsp_err);
endmodule

// File: tb/irq_src_ctrl_test.sv
`timescale 1ns/1ps
module irq_src_ctrl_test;
    import isc_pkg::*;
    localparam int N = 16;
    localparam int B = 'h1000;

    logic clk = 1'b0, rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [N-1:0] line;
    logic cmd_valid, cmd_ready, rsp_valid, rsp_err, pres_valid, pres_ready;
    logic [2:0] cmd_op;
    logic [15:0] cmd_num, pres_num;
    logic [3:0] cmd_srv, pres_srv;
    logic [7:0] cmd_prio, pres_prio;

    irq_src_ctrl uut (
        .clk(clk), .rst(rst), .line_in(line),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_num(cmd_num), .cmd_srv(cmd_srv), .cmd_prio(cmd_prio),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .pres_valid(pres_valid), .pres_ready(pres_ready),
        .pres_srv(pres_srv), .pres_num(pres_num), .pres_prio(pres_prio)
    );

    int checks = 0, fails = 0;
    int q_num[$], q_srv[$], q_prio[$];
    int last_err, last_rsp;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(int op, int num, int srv, int prio);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_num = 16'(num);
        cmd_srv = 4'(srv); cmd_prio = 8'(prio);
        @(negedge clk);
        cmd_valid = 1'b0;
        last_err = int'(rsp_err);
        last_rsp = int'(rsp_valid);
    endtask

    task automatic drain();
        q_num.delete(); q_srv.delete(); q_prio.delete();
        pres_ready = 1'b1;
        for (int c = 0; c < 40; c++) begin
            if (!pres_valid) break;
            q_num.push_back(int'(pres_num));
            q_srv.push_back(int'(pres_srv));
            q_prio.push_back(int'(pres_prio));
            @(negedge clk);
        end
        pres_ready = 1'b0;
    endtask

    task automatic expect_at(int k, string tag, int idx, int srv, int prio);
        if (q_num.size() > k) begin
            chk({tag, " num"}, q_num[k], B + idx);
            chk({tag, " srv"}, q_srv[k], srv);
            chk({tag, " prio"}, q_prio[k], prio);
        end
    endtask

    task automatic expect_one(string tag, int idx, int srv, int prio);
        chk({tag, " count"}, q_num.size(), 1);
        expect_at(0, tag, idx, srv, prio);
    endtask

    task automatic expect_none(string tag);
        chk(tag, q_num.size(), 0);
    endtask

    initial begin
        line = '0; cmd_valid = 0; cmd_op = 0; cmd_num = 0; cmd_srv = 0;
        cmd_prio = 0; pres_ready = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 pres_valid after reset", int'(pres_valid), 0);
        chk("R1 cmd_ready after reset", int'(cmd_ready), 1);
        chk("R1 rsp_valid after reset", int'(rsp_valid), 0);

        line = '1;
        @(negedge clk); @(negedge clk);
        drain(); expect_none("R1 R2 masked sources silent");

        for (int i = 0; i < 8; i++) begin
            send(OP_CFG, B + i, i, 'h10 + i);
            chk("R8 R10 cfg accepted", last_err, 0);
            drain(); expect_one("R4 R8 level present on cfg", i, i, 'h10 + i);
        end
        for (int j = 8; j < 16; j++) begin
            send(OP_CFG, B + j, (j * 3) % 16, 'h20 + j);
            drain(); expect_one("R3 R8 pending msg on unmask", j, (j * 3) % 16, 'h20 + j);
        end
        send(OP_CFG, B + 8, 8, 'h28);
        drain(); expect_none("R3 pending presented once");

        send(OP_RESEND, 0, 0, 0);
        chk("R6 resend response", last_err, 0);
        drain(); expect_none("R4 R6 sent level and unrejected msg quiet");

        send(OP_EOI, B + 0, 0, 0);
        send(OP_EOI, B + 9, 0, 0);
        send(OP_RESEND, 0, 0, 0);
        drain(); expect_one("R7 eoi re-arms level only", 0, 0, 'h10);

        send(OP_REJECT, B + 14, 0, 0);
        drain(); expect_none("R5 reject alone silent");
        send(OP_RESEND, 0, 0, 0);
        drain(); expect_one("R5 R6 rejected msg returns", 14, 10, 'h2E);

        send(OP_REJECT, B + 12, 0, 0);
        send(OP_REJECT, B + 2, 0, 0);
        send(OP_REJECT, B + 10, 0, 0);
        send(OP_RESEND, 0, 0, 0);
        chk("R11 lowest index first", int'(pres_num), B + 2);
        chk("R12 busy while pending", int'(cmd_ready), 0);
        @(negedge clk); @(negedge clk);
        chk("R11 num held in stall", int'(pres_num), B + 2);
        chk("R11 prio held in stall", int'(pres_prio), 'h12);
        drain();
        chk("R6 R11 resend count", q_num.size(), 3);
        expect_at(0, "R5 R6 order 0", 2, 2, 'h12);
        expect_at(1, "R6 R11 order 1", 10, 14, 'h2A);
        expect_at(2, "R6 R11 order 2", 12, 4, 'h2C);
        chk("R12 ready after drain", int'(cmd_ready), 1);
        send(OP_RESEND, 0, 0, 0);
        drain(); expect_none("R6 rejected flags cleared");

        send(OP_OFF, B + 11, 0, 0);
        line[11] = 1'b0; @(negedge clk);
        line[11] = 1'b1; @(negedge clk);
        drain(); expect_none("R9 R2 disabled msg silent");
        send(OP_ON, B + 11, 0, 0);
        drain(); expect_one("R9 R3 enable restores prio", 11, 1, 'h2B);

        send(OP_OFF, B + 3, 0, 0);
        send(OP_EOI, B + 3, 0, 0);
        send(OP_RESEND, 0, 0, 0);
        drain(); expect_none("R9 R2 disabled level silent");
        send(OP_ON, B + 3, 0, 0);
        drain(); expect_one("R9 R4 enable re-evaluates level", 3, 3, 'h13);

        send(OP_REJECT, B + 16, 0, 0);
        chk("R10 above range error", last_err, 1);
        chk("R10 response valid", last_rsp, 1);
        send(OP_CFG, B - 1, 0, 0);
        chk("R10 below range error", last_err, 1);
        send(7, B + 1, 0, 0);
        chk("R10 unknown opcode error", last_err, 1);
        send(OP_EOI, B + 15, 0, 0);
        chk("R10 top index valid", last_err, 0);
        send(OP_RESEND, 0, 0, 0);
        drain(); expect_none("R10 refused command changed nothing");

        line[13] = 1'b0; @(negedge clk);
        drain(); expect_none("R3 msg falling edge silent");
        line[13] = 1'b1; @(negedge clk);
        drain(); expect_one("R3 unmasked msg edge presents", 13, 7, 'h2D);

        line[4] = 1'b0; @(negedge clk);
        send(OP_EOI, B + 4, 0, 0);
        send(OP_RESEND, 0, 0, 0);
        drain(); expect_none("R4 deasserted level quiet");
        line[4] = 1'b1; @(negedge clk);
        drain(); expect_one("R4 level rise presents", 4, 4, 'h14);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog R11 actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule